// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between eight peripheral request lines and a processor. It watches the request lines and raises one interrupt request toward the processor whenever an unmasked line is active. Requests are level-sensitive: a line counts as pending only while it is held high. Software sets the block up through a small write port with four addresses. These hold a mask, a vector base, a mode select and a command register. The command register carries the end-of-interrupt command.

In vectored mode the processor answers with two low pulses on an active-low acknowledge line. On the first pulse the block picks the winning source and marks it in service. The choice made then is final. During the second pulse the block drives an 8-bit vector onto the data bus. In poll mode the processor reads the block instead, and the read returns the winning source number. The block tracks which sources are in service. While a source is in service, requests of equal or lower priority are held off. A non-specific end-of-interrupt command releases the highest-priority source that is in service.

Top module: `vpic`

## Requirements
- R1: `irq_out` is high exactly when some input is high, unmasked, and of strictly higher priority than every in-service source.
- R2: A mask bit of 1 hides that input. After reset the mask is 8'hFF, so every input is hidden.
- R3: Priority is fixed. Input 0 is the highest and input 7 the lowest. When several inputs are eligible together, the lowest index wins.
- R4: The vector is {base[7:3], source[2:0]}. It is driven from the first clock edge that sees the second acknowledge pulse low, and it stays driven until that pulse goes high.
- R5: The winner is latched, and its in-service bit is set, on the first clock edge that sees the first pulse low. A request that arrives between the pulses does not change the vector.
- R6: A request at or below the level of the highest in-service source does not raise `irq_out`. A strictly higher request does raise it and can be acknowledged, which nests the two sources.
- R7: Writing address 3 with data bit 5 set clears the highest-priority in-service bit.
- R8: In poll mode (address 2, bit 0 = 1), a read returns {any, 4'b0, source[2:0]} on the same cycle. If something was pending, the clock edge that ends the read sets that source's in-service bit. If nothing was pending, the read returns 8'h00.
- R9: `data_oe` is low except during the second acknowledge pulse and during a poll read. In particular, it is low during the first pulse.
- R10: If nothing is eligible at the first pulse, the vector carries source 7 and no in-service bit is set.
- R11: The write port decodes four addresses: 0 is the mask, 1 is the vector base, 2 is the mode and 3 is the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Poll read strobe |
| irq_in | input | 8 | Request lines, bit 0 highest priority |
| inta_n | input | 1 | Active-low acknowledge pulses |
| irq_out | output | 1 | Interrupt request to the processor |
| data_o | output | 8 | Vector or poll result |
| data_oe | output | 1 | Data bus drive enable |

## Verification
The bench covers the following cases:
- A single request, to confirm how the vector is formed.
- Two simultaneous requests, to separate the winner from the loser.
- A higher request raised between the two pulses, to show that the choice is frozen at the first pulse.
- A higher request arriving while a lower source is in service, to show nesting.
- An equal or lower request arriving while a source is in service, to show hold-off.
- Acknowledge pulses with no request pending, to check the vector returned and that no in-service bit is set.
- Poll reads with and without a pending source, to check the returned value and the in-service marking.
- Masked inputs and the reset state, to show that hidden inputs never raise the request.

// File: rtl/vpic.sv
module vpic #(
  parameter int N_SRC = 8,
  localparam int IW = $clog2(N_SRC)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic [7:0] irq_in,
  input  logic       inta_n,
  output logic       irq_out,
  output logic [7:0] data_o,
  output logic       data_oe
);

  logic [N_SRC-1:0] mask_q, isr_q, isr_n;
  logic [4:0]       base_q;
  logic             poll_q;
  logic             inta_q, second_q, drv_q;
  logic [IW-1:0]    cur_id_q;

  logic [N_SRC-1:0] pend, elig;
  logic [IW:0]      isr_lvl;
  logic [IW-1:0]    win_id, isr_top;
  logic             win_any;
  logic             fall, first_ack, eoi_wr, poll_rd, set_req;

  assign pend    = irq_in & ~mask_q;
  assign fall    = !inta_n && inta_q && !poll_q;
  assign first_ack = fall && !second_q;
  assign eoi_wr  = wr_en && (wr_addr == 2'd3) && wr_data[5];
  assign poll_rd = rd_en && poll_q;

  always_comb begin
    isr_lvl = (IW+1)'(N_SRC);
    isr_top = '0;
    for (int i = N_SRC-1; i >= 0; i--)
      if (isr_q[i]) begin
        isr_lvl = (IW+1)'(i);
        isr_top = IW'(i);
      end
  end

  always_comb
    for (int i = 0; i < N_SRC; i++)
      elig[i] = pend[i] && ((IW+1)'(i) < isr_lvl);

  always_comb begin
    win_id  = IW'(N_SRC-1);
    win_any = 1'b0;
    for (int i = N_SRC-1; i >= 0; i--)
      if (elig[i]) begin
        win_id  = IW'(i);
        win_any = 1'b1;
      end
  end

  assign irq_out = win_any;
  assign set_req = (first_ack || poll_rd) && win_any;

  always_comb begin
    isr_n = isr_q;
    if (eoi_wr && |isr_q) isr_n[isr_top] = 1'b0;
    if (set_req)          isr_n[win_id]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_q   <= '1;
      base_q   <= '0;
      poll_q   <= 1'b0;
      isr_q    <= '0;
      inta_q   <= 1'b1;
      second_q <= 1'b0;
      drv_q    <= 1'b0;
      cur_id_q <= '0;
    end else begin
      inta_q <= inta_n;
      isr_q  <= isr_n;
      if (wr_en)
        case (wr_addr)
          2'd0: mask_q <= wr_data[N_SRC-1:0];
          2'd1: base_q <= wr_data[7:3];
          2'd2: poll_q <= wr_data[0];
          default: ;
        endcase
      if (fall) begin
        if (!second_q) begin
          second_q <= 1'b1;
          cur_id_q <= win_id;
        end else begin
          second_q <= 1'b0;
          drv_q    <= 1'b1;
        end
      end else if (inta_n) begin
        drv_q <= 1'b0;
      end
    end

  assign data_oe = (drv_q && !inta_n) || poll_rd;
  assign data_o  = poll_rd ? {win_any, 4'b0000, win_any ? win_id : IW'(0)}
                 : drv_q   ? {base_q, cur_id_q} : 8'h00;

  a_r1_irq_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> |(irq_in & ~mask_q));

  a_r9_oe_only_in_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!inta_n || rd_en));

  a_r4_vector_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && !rd_en && $past(data_oe) && !$past(rd_en)) |-> $stable(data_o));

  a_r5_first_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (first_ack && win_any && !eoi_wr) |=>
      ($countones(isr_q) == $past($countones(isr_q)) + 1));

  a_r7_eoi_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && |isr_q && !set_req) |=>
      ($countones(isr_q) + 1 == $past($countones(isr_q))));

endmodule

// File: tb/sim_vpic.sv
module sim_vpic;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, inta_n = 1;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0, irq_in = 0;
  logic irq_out, data_oe;
  logic [7:0] data_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  vpic u0 (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_en, .irq_in,
           .inta_n, .irq_out, .data_o, .data_oe);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; tick; wr_en = 0;
  endtask

  task automatic ack(input logic [7:0] mid, output logic [7:0] vec);
    inta_n = 0; tick;
    #1 chk("R9 first pulse", {7'b0, data_oe}, 8'h00);
    inta_n = 1; irq_in = mid; tick;
    inta_n = 0; tick;
    #1 chk("R4 oe second pulse", {7'b0, data_oe}, 8'h01);
    vec = data_o;
    inta_n = 1; #1 chk("R9 after pulse", {7'b0, data_oe}, 8'h00);
    tick;
  endtask

  task automatic irq_is(string req, logic [7:0] r, logic e);
    irq_in = r; #1 chk(req, {7'b0, irq_out}, {7'b0, e});
  endtask

  task automatic t_reset;
    chk("R2 reset irq", {7'b0, irq_out}, 8'h00);
    chk("R9 reset oe", {7'b0, data_oe}, 8'h00);
    irq_is("R2 reset masked", 8'hFF, 0);
    irq_in = 0;
  endtask

  task automatic t_single;
    logic [7:0] v;
    wr(2'd0, 8'h00); wr(2'd1, 8'h40);
    irq_is("R1 single", 8'h20, 1);
    ack(8'h20, v); chk("R4 R11 vector", v, 8'h45);
    irq_in = 0; wr(2'd3, 8'h20);
  endtask

  task automatic t_prio;
    logic [7:0] v;
    irq_in = 8'h44; ack(8'h44, v); chk("R3 winner", v, 8'h42);
    irq_is("R6 hold off lower", 8'h44, 0);
    irq_is("R6 hold off equal", 8'h04, 0);
    irq_in = 8'h40; wr(2'd3, 8'h20);
    irq_is("R7 eoi releases", 8'h40, 1);
    ack(8'h40, v); chk("R3 loser next", v, 8'h46);
    irq_in = 0; wr(2'd3, 8'h20);
  endtask

  task automatic t_freeze_nest;
    logic [7:0] v;
    irq_in = 8'h10; ack(8'h12, v); chk("R5 frozen", v, 8'h44);
    irq_is("R6 higher nests", 8'h02, 1);
    ack(8'h02, v); chk("R6 nested vector", v, 8'h41);
    irq_in = 0; wr(2'd3, 8'h20);
    irq_is("R7 highest cleared first", 8'h20, 0);
    irq_is("R7 level 4 still held", 8'h08, 1);
    irq_in = 0; wr(2'd3, 8'h20);
    irq_is("R7 all clear", 8'h20, 1);
    irq_in = 0;
  endtask

  task automatic t_mask_spur;
    logic [7:0] v;
    wr(2'd0, 8'h08);
    irq_is("R2 masked line", 8'h08, 0);
    ack(8'h08, v); chk("R10 spurious vector", v, 8'h47);
    irq_is("R10 no isr set", 8'h80, 1);
    irq_in = 0; wr(2'd0, 8'h00);
  endtask

  task automatic t_poll;
    wr(2'd2, 8'h01);
    irq_in = 8'h40; rd_en = 1;
    #1 chk("R8 poll value", data_o, 8'h86);
    chk("R9 poll oe", {7'b0, data_oe}, 8'h01);
    tick; rd_en = 0;
    #1 chk("R9 oe after poll", {7'b0, data_oe}, 8'h00);
    irq_is("R8 poll marks isr", 8'h80, 0);
    irq_in = 0; rd_en = 1;
    #1 chk("R8 empty poll", data_o, 8'h00);
    tick; rd_en = 0;
    wr(2'd3, 8'h20);
    irq_is("R8 R7 released", 8'h80, 1);
    irq_in = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset;
    rst_n = 1; tick;
    t_single;
    t_prio;
    t_freeze_nest;
    t_mask_spur;
    t_poll;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule